// File: doc/BRIEF.md
# Subsystem Reset and Clock-Gating Controller

This block holds an 8-bit control word that a local microprocessor writes, and turns it into reset and clock-gating controls for three internal subsystems: host, buffer and disk. Each subsystem has a reset bit and a power-down enable bit. Power-on reset sets all three reset bits. Each reset bit then stays set until firmware clears it. The disk reset also drives a separate reset output for the error-correction logic.

When a subsystem's power-down enable is clear, its gated clock runs on every cycle. When the enable is set, the clock pulses only while that subsystem raises its activity request. The gated clock is also forced on while the subsystem is in reset, so that its synchronous reset is applied. Configuration changes cross into each subsystem clock domain through a two-flop synchronizer. The result then passes a low-transparent latch, so each gated clock is either a whole pulse or no pulse.

The buffer subsystem's refresh clock is never gated. The top bit of the word drives a global pull-up disable output, and bit 6 is reserved.

Top module: `blk_rst_gate_ctrl`

## Requirements
- R1: While `por_n` is low, and after it rises until the first write, `rd_data` reads 0x07. `sub_rst` is 3'b111, `ecc_rst` is 1 and `pullup_dis` is 0. A write strobe while `por_n` is low has no effect.
- R2: A write stores `wr_data` on the rising `clk` edge. Bit 6 always reads back as 0, and `rd_data` shows the stored word on the cycle after the write.
- R3: Reset bits sit at positions 0 (host), 1 (buffer) and 2 (disk) and drive `sub_rst[0..2]` directly. A bit keeps its value until a write changes it. `ecc_rst` always equals the disk reset bit.
- R4: Power-down enables sit at bits 3 (host), 4 (buffer) and 5 (disk). When an enable is 0, `gclk[i]` copies `sub_clk[i]` on every cycle, whatever the state of `act_req[i]`.
- R5: When the power-down enable is 1, the reset bit is 0 and `act_req[i]` is 0, `gclk[i]` stays low.
- R6: With gating active, raising `act_req[i]` during a low phase of `sub_clk[i]` lets the very next high phase through to `gclk[i]`. Dropping it during a low phase blocks the next high phase.
- R7: A written change to a power-down or reset bit first reaches `gclk[i]` in the high phase that follows the third `sub_clk[i]` rising edge after the write edge.
- R8: The gate enable changes only while `sub_clk[i]` is low, so `gclk[i]` never carries a shortened pulse and is low during every low phase.
- R9: While reset bit i is 1, `gclk[i]` runs even if the power-down enable is 1 and `act_req[i]` is 0.
- R10: `refr_gclk` follows `sub_clk[1]` whatever the buffer power-down bit holds.
- R11: `pullup_dis` equals bit 7 of the stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Microprocessor register clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current control word |
| sub_clk | input | 3 | Subsystem clocks: 0 host, 1 buffer, 2 disk |
| act_req | input | 3 | Activity requests, one per subsystem clock domain |
| sub_rst | output | 3 | Subsystem resets, active high |
| ecc_rst | output | 1 | Error-correction reset, follows the disk reset bit |
| gclk | output | 3 | Gated subsystem clocks |
| refr_gclk | output | 1 | Ungated refresh clock taken from the buffer clock |
| pullup_dis | output | 1 | Global pull-up disable |

## Verification
Two events can land in the same cycle: a firmware write that turns gating on, and a change of a subsystem's activity request. The bench provokes this by driving the write strobe and a new `act_req` pattern at the same instant. The new request is seen at once. The write, on the other hand, must keep the clocks running for exactly two more high phases before only the requested subsystem keeps pulsing. The bench judges each of these phases against the synchronizer latency derived from R6 and R7.

// File: rtl/blk_rst_gate_ctrl.sv
module blk_rst_gate_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic [2:0] sub_clk,
  input  logic [2:0] act_req,
  output logic [2:0] sub_rst,
  output logic       ecc_rst,
  output logic [2:0] gclk,
  output logic       refr_gclk,
  output logic       pullup_dis
);
  localparam logic [7:0] WMASK   = 8'hBF;
  localparam logic [7:0] POR_VAL = 8'h07;
  localparam int         TOP     = SYNC_STAGES - 1;

  logic [7:0] ctrl_q;
  logic [2:0] on_req;
  logic [2:0] sync_on;
  logic [2:0] en_lat;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)     ctrl_q <= POR_VAL;
    else if (wr_en) ctrl_q <= wr_data & WMASK;

  assign rd_data    = ctrl_q;
  assign sub_rst    = ctrl_q[2:0];
  assign ecc_rst    = ctrl_q[2];
  assign pullup_dis = ctrl_q[7];
  assign refr_gclk  = sub_clk[1];
  assign on_req     = ctrl_q[2:0] | ~ctrl_q[5:3];

  for (genvar i = 0; i < 3; i++) begin : g_sub
    logic [TOP:0] sq;
    logic         en_q;

    always_ff @(posedge sub_clk[i] or negedge por_n)
      if (!por_n) sq <= '1;
      else        sq <= {sq[TOP-1:0], on_req[i]};

    always_latch
      if (!sub_clk[i]) en_q = sq[TOP] | act_req[i];

    assign sync_on[i] = sq[TOP];
    assign en_lat[i]  = en_q;
    assign gclk[i]    = sub_clk[i] & en_q;
  end
endmodule

module blk_rst_gate_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic [2:0] sub_rst,
  input logic       ecc_rst,
  input logic [2:0] sub_clk,
  input logic [2:0] act_req,
  input logic [2:0] sync_on,
  input logic [2:0] en_lat
);
  p_write_r2: assert property (@(posedge clk) disable iff (!por_n)
    wr_en |=> rd_data == ($past(wr_data) & 8'hBF));

  p_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
    !wr_en |=> $stable(rd_data));

  p_ecc_r3: assert property (@(posedge clk) disable iff (!por_n)
    ecc_rst == sub_rst[2]);

  for (genvar i = 0; i < 3; i++) begin : g_a
    p_cfg_on_r4: assert property (@(posedge sub_clk[i]) disable iff (!por_n)
      sync_on[i] |-> en_lat[i]);

    p_gated_off_r5: assert property (@(posedge sub_clk[i]) disable iff (!por_n)
      (!sync_on[i] && !act_req[i]) |-> !en_lat[i]);

    p_demand_on_r6: assert property (@(posedge sub_clk[i]) disable iff (!por_n)
      act_req[i] |-> en_lat[i]);

    always @(en_lat[i])
      if (por_n && !$isunknown(en_lat[i]))
        p_glitch_free_r8: assert (!sub_clk[i]);
  end
endmodule

bind blk_rst_gate_ctrl blk_rst_gate_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .sub_rst(sub_rst), .ecc_rst(ecc_rst),
  .sub_clk(sub_clk), .act_req(act_req), .sync_on(sync_on), .en_lat(en_lat)
);

// File: tb/blk_rst_gate_ctrl_test.sv
`timescale 1ns/100ps
module blk_rst_gate_ctrl_test;
  logic       clk = 1'b0;
  logic       por_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [2:0] act;
  logic [2:0] sub_rst;
  logic       ecc_rst;
  logic [2:0] gclk;
  logic       refr_gclk;
  logic       pullup_dis;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  blk_rst_gate_ctrl uut (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sub_clk({3{clk}}), .act_req(act),
    .sub_rst(sub_rst), .ecc_rst(ecc_rst), .gclk(gclk),
    .refr_gclk(refr_gclk), .pullup_dis(pullup_dis)
  );

  // {control word, act_req, expected gclk in the high phase}
  localparam logic [13:0] VEC [10] = '{
    {8'h00, 3'b000, 3'b111},
    {8'h38, 3'b000, 3'b000},
    {8'h38, 3'b101, 3'b101},
    {8'h38, 3'b010, 3'b010},
    {8'h28, 3'b000, 3'b010},
    {8'h39, 3'b000, 3'b001},
    {8'h3E, 3'b000, 3'b110},
    {8'h18, 3'b000, 3'b100},
    {8'hFF, 3'b000, 3'b111},
    {8'h40, 3'b000, 3'b111}
  };

  task automatic chk(input string req, input logic [7:0] actual, input logic [7:0] expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); #1 wr_en = 1'b1; wr_data = d;
    @(negedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic hi;
    @(posedge clk); #1;
  endtask

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    wr_en = 1'b0; wr_data = 8'h00; act = 3'b000; por_n = 1'b1;
    #1 por_n = 1'b0;
    repeat (3) hi();
    chk("R1 word", rd_data, 8'h07);
    chk("R1 sub_rst", {5'd0, sub_rst}, 8'h07);
    chk("R1 ecc_rst", {7'd0, ecc_rst}, 8'h01);
    chk("R1 pullup", {7'd0, pullup_dis}, 8'h00);
    chk("R1 R9 gclk", {5'd0, gclk}, 8'h07);
    @(negedge clk); #1 por_n = 1'b1;
    repeat (2) hi();
    chk("R1 after release", rd_data, 8'h07);

    for (int n = 0; n < 10; n++) begin
      logic [7:0] cfg;
      cfg = VEC[n][13:6];
      act = VEC[n][5:3];
      wr(cfg);
      repeat (4) hi();
      chk("R2 readback", rd_data, cfg & 8'hBF);
      chk("R3 sub_rst", {5'd0, sub_rst}, {5'd0, cfg[2:0]});
      chk("R3 ecc_rst", {7'd0, ecc_rst}, {7'd0, cfg[2]});
      chk("R11 pullup", {7'd0, pullup_dis}, {7'd0, cfg[7]});
      chk("R4 R5 R6 R9 gclk", {5'd0, gclk}, {5'd0, VEC[n][2:0]});
      chk("R10 refresh high", {7'd0, refr_gclk}, 8'h01);
    end

    // R3: bits hold with no write
    act = 3'b000;
    wr(8'h05);
    repeat (10) hi();
    chk("R3 sticky", {5'd0, sub_rst}, 8'h05);

    // R7: gating off -> on latency
    wr(8'h38);
    repeat (4) hi();
    wr(8'h00);
    hi(); chk("R7 on edge+1", {5'd0, gclk}, 8'h00);
    hi(); chk("R7 on edge+2", {5'd0, gclk}, 8'h00);
    hi(); chk("R7 on edge+3", {5'd0, gclk}, 8'h07);

    // R7: gating on -> off latency
    wr(8'h38);
    hi(); chk("R7 off edge+1", {5'd0, gclk}, 8'h07);
    hi(); chk("R7 off edge+2", {5'd0, gclk}, 8'h07);
    hi(); chk("R7 off edge+3", {5'd0, gclk}, 8'h00);

    // R7 R9: reset bit forces the clock on after the same latency
    wr(8'h3A);
    hi(); chk("R3 reset at once", {5'd0, sub_rst}, 8'h02);
    chk("R9 edge+1", {5'd0, gclk}, 8'h00);
    hi(); hi(); chk("R9 edge+3", {5'd0, gclk}, 8'h02);

    // R6: no latency on activity requests
    wr(8'h38);
    repeat (4) hi();
    @(negedge clk); #1 act = 3'b100;
    hi(); chk("R6 request on", {5'd0, gclk}, 8'h04);
    @(negedge clk); #1 act = 3'b000;
    hi(); chk("R6 request off", {5'd0, gclk}, 8'h00);

    // R10: refresh clock runs while buffer gating is on
    chk("R10 refresh high", {7'd0, refr_gclk}, 8'h01);
    @(negedge clk); #1 chk("R10 refresh low", {7'd0, refr_gclk}, 8'h00);

    // Same-cycle write and activity change
    wr(8'h00);
    act = 3'b010;
    repeat (4) hi();
    @(negedge clk); #1 wr_en = 1'b1; wr_data = 8'h38; act = 3'b001;
    @(negedge clk); #1 wr_en = 1'b0;
    chk("R8 low phase", {5'd0, gclk}, 8'h00);
    hi(); chk("R7 conflict edge+1", {5'd0, gclk}, 8'h07);
    hi(); chk("R7 conflict edge+2", {5'd0, gclk}, 8'h07);
    hi(); chk("R6 conflict edge+3", {5'd0, gclk}, 8'h01);

    // R1: mid-run power-on reset, writes ignored
    act = 3'b000;
    wr(8'hB8);
    repeat (4) hi();
    @(negedge clk); #1 por_n = 1'b0; wr_en = 1'b1; wr_data = 8'h38;
    hi(); chk("R1 mid-run word", rd_data, 8'h07);
    chk("R1 R9 mid-run gclk", {5'd0, gclk}, 8'h07);
    chk("R1 mid-run pullup", {7'd0, pullup_dis}, 8'h00);
    @(negedge clk); #1 wr_en = 1'b0; por_n = 1'b1;
    hi(); chk("R1 write ignored", rd_data, 8'h07);

    finish_run();
  end
endmodule